// File: doc/BRIEF.md
# Changed Zone Log Generator

This block produces the changed-zone log page for a single zoned namespace. It keeps one pending flag per zone and one pending flag for the namespace. Other zone logic raises these flags when a zone's descriptor changes. When the host asks for the log, the block checks the request fields. If they are valid, it walks the zone table from the lowest index upward and streams the page out as 64-bit little-endian words. Each word carries a valid strobe, and the final word is marked.

The first word holds the number of reported zones, followed by six zero bytes. Every later word is one slot, holding the start address of a reported zone or zero. A zone is reported when its pending flag is set and its attribute byte is non-zero. If zones were flagged but none of them could be reported, the count takes a reserved marker value. A retain input on the request decides whether the per-zone flags of the scanned zones are cleared. The namespace flag is cleared by every successful read.

Because the count is written before the entries, the block scans the table twice. The first pass counts and the second pass emits. The page size is set by a slot-count parameter: 511 slots give a 4096-byte page.

Top module: `zone_change_log`

## Requirements
- R1: While reset is held and in the first cycle after it, the block is not busy, raises no word valid, no last and no done, and all zone flags and the namespace flag read 0.
- R2: A pulse on the flag-set input with a zone index sets that zone's flag and the namespace flag, both visible from the next cycle. A set and a clear of the same flag in the same cycle leave it set. No zone flag rises without a set pulse.
- R3: A request is rejected if any of these holds: reporting is disabled, the namespace id is 0, the namespace id is above the namespace count, the command set id differs from the namespace's, the offset is non-zero, or the length differs from 8*(MAX_ENTRIES+1) bytes. A rejection gives a one-cycle done with status 0x4002 (bit 14 do-not-retry, code 0x02 invalid field). It produces no word and changes no flag.
- R4: A valid request produces exactly MAX_ENTRIES+1 valid words. Log byte k is bits [8*(k%8)+7 : 8*(k%8)] of word k/8. Word 0 carries the 16-bit count in bits 15:0 and zero in bits 63:16. The last word comes with last and done asserted and status 0x0000.
- R5: A zone is listed only when its flag is set and its attribute byte is non-zero. Entries are listed in ascending zone index. The entry value is the zone index shifted left by ZONE_SHIFT.
- R6: The scan stops as soon as MAX_ENTRIES entries are filled. Zones after that point are neither listed nor cleared.
- R7: The count equals the number of listed entries. The exception is when at least one scanned zone was flagged but none was listed: the count is then 0xFFFF.
- R8: Slots after the last listed entry are output as zero.
- R9: With retain at 0, every scanned zone whose flag was set has its flag cleared, whether or not it was listed. With retain at 1, no zone flag changes.
- R10: Once a successful read completes, the namespace flag reads 0 whatever the retain value is, unless a set arrives in that same cycle.
- R11: A request presented while the block is busy is ignored: the read in progress completes unchanged with a single done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_set_valid_i | input | 1 | Marks one zone as changed |
| flag_set_idx_i | input | IDX_W | Index of the zone to mark |
| zone_attr_i | input | 8*NUM_ZONES | Attribute byte of each zone, zone z at bits 8z+7:8z |
| req_valid_i | input | 1 | Log read request strobe |
| req_enable_i | input | 1 | Zone change reporting enabled |
| req_nsid_i | input | 32 | Requested namespace id |
| ns_count_i | input | 32 | Number of namespaces |
| req_csi_i | input | 8 | Command set id of the request |
| ns_csi_i | input | 8 | Command set id of the namespace |
| req_offset_i | input | 64 | Requested byte offset |
| req_len_i | input | 32 | Requested length in bytes |
| req_retain_i | input | 1 | Keep per-zone flags after the read |
| busy_o | output | 1 | A read is in progress |
| word_valid_o | output | 1 | word_o holds a log word |
| word_o | output | 64 | Log word, little-endian |
| word_last_o | output | 1 | Final word of the page |
| done_o | output | 1 | Request finished, status_o valid |
| status_o | output | 16 | 0x0000 success, 0x4002 rejected |
| zone_pend_o | output | NUM_ZONES | Per-zone pending flags |
| ns_pend_o | output | 1 | Namespace pending flag |

## Verification
The assertions check these rules on every cycle:
- a rejection streams nothing and moves no flag;
- a zone flag only rises after a set pulse;
- the last word always comes with a successful done;
- no word appears while the block has been idle for two cycles;
- the namespace flag is low after a successful done.

Other behaviour can only be shown by the bench's scenarios. This covers the page contents, the count rules including the 0xFFFF marker, and ascending order with a stop at the slot limit. It also covers which flags retain keeps, and that a second request arriving mid-read is ignored. The bench sweeps every flag pattern of an eight-zone table, with varied attributes and both retain values, and compares the results against a model of the table.

// File: rtl/zcl_pkg.sv
package zcl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COUNT,
        ST_HEAD,
        ST_BODY,
        ST_PAD
    } zcl_state_e;

    localparam logic [15:0] ZCL_STATUS_OK    = 16'h0000;
    localparam logic [15:0] ZCL_STATUS_BAD   = 16'h4002;
    localparam logic [15:0] ZCL_COUNT_MARKER = 16'hFFFF;

endpackage

// File: rtl/zcl_req_check.sv
module zcl_req_check #(
    parameter int LOG_BYTES = 4096
) (
    input  logic        enable_i,
    input  logic [31:0] nsid_i,
    input  logic [31:0] ns_count_i,
    input  logic [7:0]  csi_i,
    input  logic [7:0]  ns_csi_i,
    input  logic [63:0] offset_i,
    input  logic [31:0] len_i,
    output logic        ok_o
);
    always_comb begin
        ok_o = enable_i
            && (nsid_i != 32'd0)
            && (nsid_i <= ns_count_i)
            && (csi_i == ns_csi_i)
            && (offset_i == 64'd0)
            && (len_i == 32'(LOG_BYTES));
    end
endmodule

// File: rtl/zcl_flag_store.sv
module zcl_flag_store #(
    parameter int NUM_ZONES = 64,
    localparam int IDX_W = $clog2(NUM_ZONES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_valid_i,
    input  logic [IDX_W-1:0]     set_idx_i,
    input  logic                 clr_valid_i,
    input  logic [IDX_W-1:0]     clr_idx_i,
    input  logic                 ns_clr_i,
    output logic [NUM_ZONES-1:0] pend_o,
    output logic                 ns_pend_o
);
    logic [NUM_ZONES-1:0] pend_d, pend_q;
    logic                 ns_d, ns_q;

    always_comb begin
        pend_d = pend_q;
        ns_d   = ns_q;
        if (clr_valid_i) pend_d[clr_idx_i] = 1'b0;
        if (ns_clr_i)    ns_d = 1'b0;
        if (set_valid_i) begin
            pend_d[set_idx_i] = 1'b1;
            ns_d              = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            ns_q   <= 1'b0;
        end else begin
            pend_q <= pend_d;
            ns_q   <= ns_d;
        end
    end

    assign pend_o    = pend_q;
    assign ns_pend_o = ns_q;
endmodule

// File: rtl/zone_change_log.sv
module zone_change_log
    import zcl_pkg::*;
#(
    parameter int NUM_ZONES   = 64,
    parameter int MAX_ENTRIES = 511,
    parameter int ZONE_SHIFT  = 16,
    localparam int IDX_W      = $clog2(NUM_ZONES),
    localparam int SLOT_W     = $clog2(MAX_ENTRIES + 1),
    localparam int LOG_BYTES  = (MAX_ENTRIES + 1) * 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flag_set_valid_i,
    input  logic [IDX_W-1:0]       flag_set_idx_i,
    input  logic [NUM_ZONES*8-1:0] zone_attr_i,
    input  logic                   req_valid_i,
    input  logic                   req_enable_i,
    input  logic [31:0]            req_nsid_i,
    input  logic [31:0]            ns_count_i,
    input  logic [7:0]             req_csi_i,
    input  logic [7:0]             ns_csi_i,
    input  logic [63:0]            req_offset_i,
    input  logic [31:0]            req_len_i,
    input  logic                   req_retain_i,
    output logic                   busy_o,
    output logic                   word_valid_o,
    output logic [63:0]            word_o,
    output logic                   word_last_o,
    output logic                   done_o,
    output logic [15:0]            status_o,
    output logic [NUM_ZONES-1:0]   zone_pend_o,
    output logic                   ns_pend_o
);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_ZONES - 1);
    localparam logic [SLOT_W-1:0] FULL     = SLOT_W'(MAX_ENTRIES);

    typedef struct packed {
        zcl_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic              any;
        logic [SLOT_W-1:0] listed;
        logic [SLOT_W-1:0] slot;
        logic              retain;
        logic [15:0]       count;
        logic              wvalid;
        logic              wlast;
        logic [63:0]       word;
        logic              done;
        logic [15:0]       status;
    } regs_t;

    regs_t r_d, r_q;

    logic              req_ok;
    logic              clr_valid;
    logic              ns_clr;
    logic              cur_pend;
    logic              cur_qual;
    logic [7:0]        cur_attr;
    logic [SLOT_W-1:0] listed_nx;
    logic [SLOT_W-1:0] slot_nx;

    zcl_req_check #(.LOG_BYTES(LOG_BYTES)) u_check (
        .enable_i   (req_enable_i),
        .nsid_i     (req_nsid_i),
        .ns_count_i (ns_count_i),
        .csi_i      (req_csi_i),
        .ns_csi_i   (ns_csi_i),
        .offset_i   (req_offset_i),
        .len_i      (req_len_i),
        .ok_o       (req_ok)
    );

    zcl_flag_store #(.NUM_ZONES(NUM_ZONES)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_valid_i (flag_set_valid_i),
        .set_idx_i   (flag_set_idx_i),
        .clr_valid_i (clr_valid),
        .clr_idx_i   (r_q.idx),
        .ns_clr_i    (ns_clr),
        .pend_o      (zone_pend_o),
        .ns_pend_o   (ns_pend_o)
    );

    always_comb begin
        cur_pend  = zone_pend_o[r_q.idx];
        cur_attr  = zone_attr_i[int'(r_q.idx)*8 +: 8];
        cur_qual  = cur_pend && (cur_attr != 8'd0);
        listed_nx = r_q.listed + SLOT_W'(cur_qual);
        slot_nx   = r_q.slot + SLOT_W'(cur_qual);

        r_d        = r_q;
        r_d.wvalid = 1'b0;
        r_d.wlast  = 1'b0;
        r_d.done   = 1'b0;
        clr_valid  = 1'b0;
        ns_clr     = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    if (req_ok) begin
                        r_d.st     = ST_COUNT;
                        r_d.idx    = '0;
                        r_d.any    = 1'b0;
                        r_d.listed = '0;
                        r_d.retain = req_retain_i;
                    end else begin
                        r_d.done   = 1'b1;
                        r_d.status = ZCL_STATUS_BAD;
                    end
                end
            end
            ST_COUNT: begin
                r_d.any    = r_q.any | cur_pend;
                r_d.listed = listed_nx;
                if (r_q.idx == LAST_IDX || listed_nx == FULL) begin
                    r_d.st    = ST_HEAD;
                    r_d.count = (listed_nx == '0 && (r_q.any || cur_pend))
                              ? ZCL_COUNT_MARKER : 16'(listed_nx);
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_HEAD: begin
                r_d.wvalid = 1'b1;
                r_d.word   = {48'd0, r_q.count};
                r_d.st     = ST_BODY;
                r_d.idx    = '0;
                r_d.slot   = '0;
            end
            ST_BODY: begin
                clr_valid = cur_pend && !r_q.retain;
                r_d.slot  = slot_nx;
                if (cur_qual) begin
                    r_d.wvalid = 1'b1;
                    r_d.word   = 64'(r_q.idx) << ZONE_SHIFT;
                end
                if (slot_nx == FULL) begin
                    r_d.st     = ST_IDLE;
                    r_d.wlast  = 1'b1;
                    r_d.done   = 1'b1;
                    r_d.status = ZCL_STATUS_OK;
                    ns_clr     = 1'b1;
                end else if (r_q.idx == LAST_IDX) begin
                    r_d.st = ST_PAD;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_PAD: begin
                r_d.wvalid = 1'b1;
                r_d.word   = 64'd0;
                r_d.slot   = r_q.slot + 1'b1;
                if (r_q.slot + 1'b1 == FULL) begin
                    r_d.st     = ST_IDLE;
                    r_d.wlast  = 1'b1;
                    r_d.done   = 1'b1;
                    r_d.status = ZCL_STATUS_OK;
                    ns_clr     = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
            r_q.status <= ZCL_STATUS_OK;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o       = (r_q.st != ST_IDLE);
    assign word_valid_o = r_q.wvalid;
    assign word_o       = r_q.word;
    assign word_last_o  = r_q.wlast;
    assign done_o       = r_q.done;
    assign status_o     = r_q.status;
endmodule

// File: rtl/zcl_checker.sv
module zcl_checker #(
    parameter int NUM_ZONES = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 flag_set_valid_i,
    input logic                 busy_o,
    input logic                 word_valid_o,
    input logic                 word_last_o,
    input logic                 done_o,
    input logic [15:0]          status_o,
    input logic [NUM_ZONES-1:0] zone_pend_o,
    input logic                 ns_pend_o
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !word_valid_o && !done_o && !busy_o); // R1

    AST_FLAG_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|(zone_pend_o & ~$past(zone_pend_o))) |-> $past(flag_set_valid_i)); // R2

    AST_REJECT_NO_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o != 16'h0000) |-> !word_valid_o); // R3

    AST_REJECT_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o != 16'h0000 && !$past(flag_set_valid_i))
        |-> (zone_pend_o == $past(zone_pend_o))); // R3

    AST_LAST_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        word_last_o |-> (word_valid_o && done_o && status_o == 16'h0000)); // R4

    AST_IDLE_NO_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !$past(busy_o)) |-> !word_valid_o); // R4

    AST_NS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o == 16'h0000 && !$past(flag_set_valid_i)) |-> !ns_pend_o); // R10

    AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R11
endmodule

bind zone_change_log zcl_checker #(.NUM_ZONES(NUM_ZONES)) u_zcl_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .flag_set_valid_i (flag_set_valid_i),
    .busy_o           (busy_o),
    .word_valid_o     (word_valid_o),
    .word_last_o      (word_last_o),
    .done_o           (done_o),
    .status_o         (status_o),
    .zone_pend_o      (zone_pend_o),
    .ns_pend_o        (ns_pend_o)
);

// File: tb/test_zone_change_log.sv
`timescale 1ns/1ps
module test_zone_change_log;
    localparam int NZ  = 8;
    localparam int MAX = 3;
    localparam int SH  = 4;
    localparam int IW  = $clog2(NZ);
    localparam int LEN = (MAX + 1) * 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            flag_set_valid_i = 1'b0;
    logic [IW-1:0]   flag_set_idx_i = '0;
    logic [NZ*8-1:0] zone_attr_i = '0;
    logic            req_valid_i = 1'b0;
    logic            req_enable_i = 1'b1;
    logic [31:0]     req_nsid_i = 32'd1;
    logic [31:0]     ns_count_i = 32'd2;
    logic [7:0]      req_csi_i = 8'h02;
    logic [7:0]      ns_csi_i = 8'h02;
    logic [63:0]     req_offset_i = 64'd0;
    logic [31:0]     req_len_i = 32'(LEN);
    logic            req_retain_i = 1'b0;
    logic            busy_o, word_valid_o, word_last_o, done_o, ns_pend_o;
    logic [63:0]     word_o;
    logic [15:0]     status_o;
    logic [NZ-1:0]   zone_pend_o;

    zone_change_log #(.NUM_ZONES(NZ), .MAX_ENTRIES(MAX), .ZONE_SHIFT(SH)) i_zone_change_log (
        .clk(clk), .rst_n(rst_n),
        .flag_set_valid_i(flag_set_valid_i), .flag_set_idx_i(flag_set_idx_i),
        .zone_attr_i(zone_attr_i), .req_valid_i(req_valid_i),
        .req_enable_i(req_enable_i), .req_nsid_i(req_nsid_i), .ns_count_i(ns_count_i),
        .req_csi_i(req_csi_i), .ns_csi_i(ns_csi_i), .req_offset_i(req_offset_i),
        .req_len_i(req_len_i), .req_retain_i(req_retain_i),
        .busy_o(busy_o), .word_valid_o(word_valid_o), .word_o(word_o),
        .word_last_o(word_last_o), .done_o(done_o), .status_o(status_o),
        .zone_pend_o(zone_pend_o), .ns_pend_o(ns_pend_o)
    );

    always #5 clk = ~clk;

    int n_total = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [NZ-1:0] model_pend = '0;
    logic          model_ns = 1'b0;
    logic [63:0]   got_w [0:MAX];
    int            got_n;
    int            got_dones;
    logic [15:0]   got_st;
    logic          got_last;
    logic [63:0]   exp_w [0:MAX];

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_total++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    endtask

    task automatic set_flags(input logic [NZ-1:0] mask);
        for (int z = 0; z < NZ; z++) begin
            if (mask[z]) begin
                @(negedge clk);
                flag_set_valid_i = 1'b1;
                flag_set_idx_i   = IW'(z);
                model_pend[z]    = 1'b1;
                model_ns         = 1'b1;
            end
        end
        @(negedge clk);
        flag_set_valid_i = 1'b0;
    endtask

    task automatic do_read(input bit poke);
        @(negedge clk);
        req_valid_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        got_n = 0;
        got_dones = 0;
        got_last = 1'b0;
        for (int c = 0; c < 200; c++) begin
            if (word_valid_o) begin
                if (got_n <= MAX) got_w[got_n] = word_o;
                got_n++;
            end
            if (done_o) begin
                got_dones++;
                got_st   = status_o;
                got_last = word_last_o;
                break;
            end
            req_valid_i = (poke && c == 2);
            @(negedge clk);
        end
        req_valid_i = 1'b0;
    endtask

    task automatic run_good(input bit retain, input bit poke, input logic [NZ*8-1:0] attr);
        int listed;
        bit any;
        logic [15:0] cnt;
        logic [NZ-1:0] next_pend;
        zone_attr_i  = attr;
        req_retain_i = retain;
        listed = 0;
        any = 0;
        next_pend = model_pend;
        for (int k = 0; k <= MAX; k++) exp_w[k] = 64'd0;
        for (int z = 0; z < NZ; z++) begin
            if (listed == MAX) break;
            if (model_pend[z]) begin
                any = 1;
                if (attr[z*8 +: 8] != 8'd0) begin
                    exp_w[1 + listed] = 64'(z) << SH;
                    listed++;
                end
                if (!retain) next_pend[z] = 1'b0;
            end
        end
        cnt = (any && listed == 0) ? 16'hFFFF : 16'(listed);
        exp_w[0] = {48'd0, cnt};
        do_read(poke);
        chk("R4 status", 64'(got_st), 64'h0);
        chk("R4 word count", 64'(got_n), 64'(MAX + 1));
        chk("R4 last flag", 64'(got_last), 64'd1);
        chk("R7 count word", got_w[0], exp_w[0]);
        for (int k = 1; k <= MAX; k++)
            chk(k > listed ? "R8 zero slot" : "R5 R6 entry", got_w[k], exp_w[k]);
        model_pend = next_pend;
        model_ns = 1'b0;
        chk("R9 zone flags after read", 64'(zone_pend_o), 64'(model_pend));
        chk("R10 namespace flag", 64'(ns_pend_o), 64'd0);
        if (poke) begin
            chk("R11 single done", 64'(got_dones), 64'd1);
            repeat (3) @(negedge clk);
            chk("R11 idle after", 64'({busy_o, done_o, word_valid_o}), 64'd0);
        end
    endtask

    task automatic run_bad(input string tag);
        do_read(1'b0);
        chk({tag, " status"}, 64'(got_st), 64'h4002);
        chk({tag, " no words"}, 64'(got_n), 64'd0);
        chk({tag, " zone flags kept"}, 64'(zone_pend_o), 64'(model_pend));
        chk({tag, " ns flag kept"}, 64'(ns_pend_o), 64'(model_ns));
    endtask

    initial begin
        #2_000_000;
        n_total++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        logic [7:0] am;
        logic [NZ*8-1:0] attr;
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", 64'({busy_o, word_valid_o, done_o, ns_pend_o}), 64'd0);
        chk("R1 reset zone flags", 64'(zone_pend_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 64'({busy_o, word_valid_o, word_last_o, done_o}), 64'd0);

        set_flags(8'b0010_0101);
        chk("R2 zone flags set", 64'(zone_pend_o), 64'(model_pend));
        chk("R2 namespace flag set", 64'(ns_pend_o), 64'd1);

        req_enable_i = 1'b0;           run_bad("R3 disabled");       req_enable_i = 1'b1;
        req_nsid_i = 32'd0;            run_bad("R3 nsid zero");
        req_nsid_i = 32'd3;            run_bad("R3 nsid range");     req_nsid_i = 32'd2;
        req_csi_i = 8'h00;             run_bad("R3 csi");            req_csi_i = 8'h02;
        req_offset_i = 64'd8;          run_bad("R3 offset");         req_offset_i = 64'd0;
        req_len_i = 32'(LEN - 8);      run_bad("R3 length");         req_len_i = 32'(LEN);

        run_good(1'b1, 1'b0, {NZ{8'h01}});
        chk("R9 retain keeps flags", 64'(zone_pend_o), 64'b0010_0101);
        run_good(1'b0, 1'b1, {NZ{8'h01}});
        set_flags(8'b0000_0110);
        run_good(1'b0, 1'b0, '0);

        for (int p = 0; p < 256; p++) begin
            am = 8'((p * 37 + 11) ^ (p >> 1));
            for (int z = 0; z < NZ; z++)
                attr[z*8 +: 8] = am[z] ? 8'(8'h10 + z) : 8'h00;
            set_flags(8'(p));
            run_good(p % 3 == 0, 1'b0, attr);
        end
        report();
    end
endmodule